// File: doc/BRIEF.md
# Manchester burst event link

This block carries 32-bit address events across one serial wire. It contains a transmit half and a receive half, and the two share a core clock. The transmit half takes a word through a four-phase request/acknowledge handshake. It prefixes the word with a two-bit alignment preamble and drives the whole frame as one Manchester-coded burst, so every bit carries its own timing edge. Between bursts the wire is held low. No filler, comma or idle symbols are sent, so the wire carries activity only when an event moves.

The receive half samples its line input at the core clock, which runs eight times faster than the half-bit rate. It starts a frame on the first rising edge after silence and treats the falling edge that follows as the first mid-bit transition. It checks the preamble, then decodes each mid-bit transition: a falling edge is a 1 and a rising edge is a 0. It re-times its window at every such edge. This lets it start cleanly after any length of silence and tolerate half-bits of 7 to 9 clocks. A decoded word is offered on its own four-phase handshake. Malformed frames are dropped and flagged with a one-cycle error pulse.

In a system, `tx_line` of one instance drives `rx_line` of the partner through the physical link.

Top module: `mbs_link`

## Requirements
- R1: A burst on `tx_line` is 34 bits: preamble bits 1 then 0, then the word most significant bit first. Each bit is two half-bits of 8 clocks. A 1 is sent high then low and a 0 is sent low then high. `tx_line` is low whenever no burst is in progress.
- R2: When idle, the transmitter latches `tx_word` on `tx_req` and starts the burst on the next cycle. `tx_ack` rises exactly 544 clocks after the first half-bit begins, stays high while `tx_req` is high, and falls the cycle after `tx_req` is seen low.
- R3: A new burst does not start until at least 32 clocks (two bit periods) after the previous burst ended.
- R4: A correctly framed burst on `rx_line` is delivered by raising `rx_req` with the word on `rx_word`. Both stay unchanged until `rx_ack` is seen high. `rx_req` then falls on the next cycle.
- R5: Decoding is correct when individual half-bits last anywhere from 7 to 9 clocks, whether mixed within a frame or all slow or all fast.
- R6: A frame that follows any length of line silence, including the first frame after reset, is decoded with no training sequence.
- R7: If a bit has no mid-bit transition, the frame is dropped, `rx_err` pulses for one cycle, and the next good frame is decoded.
- R8: If the line goes quiet before all 32 payload bits have arrived, the frame is dropped and `rx_err` pulses.
- R9: If the second preamble bit is not 0, the frame is dropped, `rx_err` pulses, and no word is delivered.
- R10: If a frame completes while an earlier word is still waiting on `rx_req`, the new frame is dropped, `rx_err` pulses once, and the waiting word is kept.
- R11: During and right after reset, `tx_line`, `tx_ack`, `rx_req` and `rx_err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, eight times the half-bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Transmit request (four-phase) |
| tx_word | input | 32 | Event word to send |
| tx_ack | output | 1 | Transmit acknowledge, burst finished |
| tx_line | output | 1 | Serial Manchester output |
| rx_line | input | 1 | Serial Manchester input (asynchronous) |
| rx_req | output | 1 | Received word available |
| rx_word | output | 32 | Received event word |
| rx_ack | input | 1 | Receive acknowledge from consumer |
| rx_err | output | 1 | One-cycle pulse on a dropped frame |

## Verification
The assertions assume that both neighbours follow the four-phase protocol. The sender holds `tx_req` high until it sees `tx_ack`. The consumer raises `rx_ack` only while `rx_req` is high and keeps it high until `rx_req` drops. They also assume that half-bits arriving on `rx_line` last 7 to 9 clocks. The directed tasks in the bench keep to these rules. Every handshake waits for the opposite edge before it changes its own line. Hand-built frames on the receive side use only 7-, 8- or 9-clock half-bits, or break framing on purpose in the error scenarios.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_ACK,
        TX_GAP
    } tx_st_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_LEAD,
        RD_BITS
    } rd_st_e;

    typedef enum logic [1:0] {
        RO_EMPTY,
        RO_FULL,
        RO_RELEASE
    } ro_st_e;

    localparam logic [1:0] ALIGN_MARK = 2'b10;

endpackage

// File: rtl/mbs_tx.sv
module mbs_tx
    import mbs_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HALF_CYC = 8,
    parameter int GAP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              ack_o,
    output logic              line_o
);

    localparam int FRAME_W = WORD_W + 2;
    localparam int HALVES  = 2 * FRAME_W;
    localparam int HW      = $clog2(HALVES);
    localparam int CW      = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int GAP_CYC = GAP_BITS * 2 * HALF_CYC;
    localparam int GW      = $clog2(GAP_CYC + 1);

    typedef struct packed {
        tx_st_e             st;
        logic [FRAME_W-1:0] frame;
        logic [HW-1:0]      hidx;
        logic [CW-1:0]      cnt;
        logic [GW-1:0]      gcnt;
    } tx_reg_t;

    tx_reg_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            TX_IDLE: begin
                if (req_i) begin
                    d.st    = TX_SEND;
                    d.frame = {ALIGN_MARK, word_i};
                    d.hidx  = '0;
                    d.cnt   = '0;
                end
            end
            TX_SEND: begin
                if (q.cnt == CW'(HALF_CYC - 1)) begin
                    d.cnt = '0;
                    if (q.hidx == HW'(HALVES - 1)) begin
                        d.st   = TX_ACK;
                        d.gcnt = '0;
                    end else begin
                        d.hidx = q.hidx + 1'b1;
                        if (q.hidx[0]) begin
                            d.frame = {q.frame[FRAME_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            TX_ACK: begin
                if (q.gcnt != GW'(GAP_CYC)) begin
                    d.gcnt = q.gcnt + 1'b1;
                end
                if (!req_i) begin
                    d.st = TX_GAP;
                end
            end
            TX_GAP: begin
                if (q.gcnt >= GW'(GAP_CYC - 1)) begin
                    d.st = TX_IDLE;
                end else begin
                    d.gcnt = q.gcnt + 1'b1;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ack_o  = (q.st == TX_ACK);
    assign line_o = (q.st == TX_SEND) & (q.frame[FRAME_W-1] ^ q.hidx[0]);

endmodule

// File: rtl/mbs_rx_dec.sv
module mbs_rx_dec
    import mbs_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HALF_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o,
    output logic              err_o
);

    localparam int BLANK = (3 * HALF_CYC) / 2;
    localparam int TOUT  = (5 * HALF_CYC) / 2;
    localparam int CW    = $clog2(TOUT + 1);
    localparam int NW    = $clog2(WORD_W);

    typedef struct packed {
        logic [2:0]        sync;
        rd_st_e            st;
        logic [CW-1:0]     cnt;
        logic [NW-1:0]     nbits;
        logic              pre_ok;
        logic [WORD_W-1:0] sr;
        logic              done;
        logic              err;
    } rd_reg_t;

    rd_reg_t q, d;
    logic    cur, prev, rise, fall;

    assign cur  = q.sync[1];
    assign prev = q.sync[2];
    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        d.sync = {q.sync[1:0], line_i};
        case (q.st)
            RD_IDLE: begin
                d.cnt = '0;
                if (rise) begin
                    d.st = RD_LEAD;
                end
            end
            RD_LEAD: begin
                if (fall) begin
                    d.st     = RD_BITS;
                    d.cnt    = '0;
                    d.nbits  = '0;
                    d.pre_ok = 1'b0;
                end else if (q.cnt >= CW'(TOUT)) begin
                    d.st  = RD_IDLE;
                    d.err = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RD_BITS: begin
                if ((rise | fall) && (q.cnt >= CW'(BLANK))) begin
                    d.cnt = '0;
                    if (!q.pre_ok) begin
                        if (fall) begin
                            d.st  = RD_IDLE;
                            d.err = 1'b1;
                        end else begin
                            d.pre_ok = 1'b1;
                        end
                    end else begin
                        d.sr = {q.sr[WORD_W-2:0], fall};
                        if (q.nbits == NW'(WORD_W - 1)) begin
                            d.done = 1'b1;
                            d.st   = RD_IDLE;
                        end else begin
                            d.nbits = q.nbits + 1'b1;
                        end
                    end
                end else if (q.cnt >= CW'(TOUT)) begin
                    d.st  = RD_IDLE;
                    d.err = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign word_o = q.sr;
    assign err_o  = q.err;

endmodule

// File: rtl/mbs_rx_out.sv
module mbs_rx_out
    import mbs_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [WORD_W-1:0] word_o,
    output logic              err_o
);

    typedef struct packed {
        ro_st_e            st;
        logic [WORD_W-1:0] word;
        logic              err;
    } ro_reg_t;

    ro_reg_t q, d;

    always_comb begin
        d     = q;
        d.err = 1'b0;
        case (q.st)
            RO_FULL:    if (ack_i)  d.st = RO_RELEASE;
            RO_RELEASE: if (!ack_i) d.st = RO_EMPTY;
            default:    ;
        endcase
        if (done_i) begin
            if (q.st == RO_EMPTY) begin
                d.word = word_i;
                d.st   = RO_FULL;
            end else begin
                d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_o  = (q.st == RO_FULL);
    assign word_o = q.word;
    assign err_o  = q.err;

endmodule

// File: rtl/mbs_link.sv
module mbs_link
    import mbs_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HALF_CYC = 8,
    parameter int GAP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_req,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_ack,
    output logic              tx_line,
    input  logic              rx_line,
    output logic              rx_req,
    output logic [WORD_W-1:0] rx_word,
    input  logic              rx_ack,
    output logic              rx_err
);

    logic              dec_done;
    logic [WORD_W-1:0] dec_word;
    logic              dec_err;
    logic              out_err;

    mbs_tx #(
        .WORD_W  (WORD_W),
        .HALF_CYC(HALF_CYC),
        .GAP_BITS(GAP_BITS)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (tx_req),
        .word_i(tx_word),
        .ack_o (tx_ack),
        .line_o(tx_line)
    );

    mbs_rx_dec #(
        .WORD_W  (WORD_W),
        .HALF_CYC(HALF_CYC)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .line_i(rx_line),
        .done_o(dec_done),
        .word_o(dec_word),
        .err_o (dec_err)
    );

    mbs_rx_out #(
        .WORD_W(WORD_W)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .done_i(dec_done),
        .word_i(dec_word),
        .ack_i (rx_ack),
        .req_o (rx_req),
        .word_o(rx_word),
        .err_o (out_err)
    );

    assign rx_err = dec_err | out_err;

endmodule

// File: rtl/mbs_link_chk.sv
module mbs_link_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_req,
    input logic [WORD_W-1:0] tx_word,
    input logic              tx_ack,
    input logic              tx_line,
    input logic              rx_line,
    input logic              rx_req,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_ack,
    input logic              rx_err
);

    // R1: the wire is quiet while the burst is being acknowledged
    assert_line_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> !tx_line);

    // R2: acknowledge held while request stays high
    assert_ack_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack && tx_req) |=> tx_ack);

    // R2: acknowledge released after request falls
    assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack && !tx_req) |=> !tx_ack);

    // R4: offered word held until taken
    assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && !rx_ack) |=> (rx_req && $stable(rx_word)));

    // R4: request withdrawn once acknowledged
    assert_rx_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && rx_ack) |=> !rx_req);

    // R7: error indication lasts a single cycle
    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> !rx_err);

endmodule

bind mbs_link mbs_link_chk #(.WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_mbs_link.sv
module test_mbs_link;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_req;
    logic [31:0] tx_word;
    logic        tx_ack;
    logic        tx_line;
    logic        rx_line;
    logic        rx_req;
    logic [31:0] rx_word;
    logic        rx_ack;
    logic        rx_err;

    logic use_tx;
    logic man_line;
    int   tests = 0;
    int   fails = 0;
    int   err_seen = 0;

    always #4 clk = ~clk;

    assign rx_line = use_tx ? tx_line : man_line;

    mbs_link i_mbs_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_req (tx_req),
        .tx_word(tx_word),
        .tx_ack (tx_ack),
        .tx_line(tx_line),
        .rx_line(rx_line),
        .rx_req (rx_req),
        .rx_word(rx_word),
        .rx_ack (rx_ack),
        .rx_err (rx_err)
    );

    always @(negedge clk) if (rx_err) err_seen++;

    task automatic chk(input logic ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int hlen(input int idx, input int mode);
        case (mode)
            1: return 9;
            2: return 7;
            3: case (idx % 6)
                   0: return 7;
                   1: return 9;
                   2: return 8;
                   3: return 9;
                   4: return 7;
                   default: return 8;
               endcase
            default: return 8;
        endcase
    endfunction

    task automatic drive_half(input logic v, input int len);
        man_line = v;
        repeat (len) @(negedge clk);
    endtask

    task automatic send_raw(input logic [1:0] pre, input logic [31:0] w,
                            input int nbits, input int kill, input int mode);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            b = (i < 2) ? pre[1-i] : w[31-(i-2)];
            drive_half(b, hlen(2*i, mode));
            drive_half((i == kill) ? b : ~b, hlen(2*i+1, mode));
        end
        man_line = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic rx_take(input logic [31:0] exp, input string tag);
        int n = 0;
        logic [31:0] first;
        while (!rx_req && n < 3000) begin @(negedge clk); n++; end
        chk(rx_req, {tag, " rx_req"}, 68'(rx_req), 68'd1);
        first = rx_word;
        repeat (5) @(negedge clk);
        chk(rx_req && rx_word == first, "R4 held", 68'(rx_word), 68'(first));
        chk(rx_word == exp, {tag, " word"}, 68'(rx_word), 68'(exp));
        rx_ack = 1'b1;
        @(negedge clk);
        chk(!rx_req, "R4 release", 68'(rx_req), 68'd0);
        rx_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic tx_burst(input logic [31:0] w);
        int k = 0;
        int n = 0;
        logic [67:0] got = '0;
        logic [67:0] exp = '0;
        logic [33:0] fr;
        fr = {2'b10, w};
        for (int i = 0; i < 34; i++) begin
            exp[67-2*i] = fr[33-i];
            exp[66-2*i] = ~fr[33-i];
        end
        tx_word = w;
        tx_req  = 1'b1;
        while (!tx_line && n < 200) begin @(negedge clk); n++; end
        while (!tx_ack && k < 1000) begin
            if (k % 8 == 3) got[67 - k/8] = tx_line;
            @(negedge clk);
            k++;
        end
        chk(got == exp, "R1 burst shape", got, exp);
        chk(k == 544, "R2 ack latency", 68'(k), 68'd544);
        tx_req = 1'b0;
        @(negedge clk);
        chk(!tx_ack, "R2 ack release", 68'(tx_ack), 68'd0);
    endtask

    task automatic t_reset();
        chk(!tx_line && !tx_ack && !rx_req && !rx_err, "R11 reset",
            68'({tx_line, tx_ack, rx_req, rx_err}), 68'd0);
    endtask

    task automatic t_loop(input logic [31:0] w, input string tag);
        use_tx = 1'b1;
        tx_burst(w);
        rx_take(w, tag);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_gap();
        int c = 1;
        use_tx = 1'b0;
        tx_burst(32'h1357_9BDF);
        tx_word = 32'h2468_ACE0;
        tx_req  = 1'b1;
        while (!tx_line && c < 500) begin @(negedge clk); c++; end
        chk(c >= 32, "R3 idle gap", 68'(c), 68'd32);
        tx_burst(32'h2468_ACE0);
        repeat (40) @(negedge clk);
        use_tx = 1'b1;
    endtask

    task automatic t_raw_good(input logic [31:0] w, input int mode, input string tag);
        int e0;
        use_tx = 1'b0;
        e0 = err_seen;
        send_raw(2'b10, w, 34, -1, mode);
        chk(err_seen == e0, {tag, " no error"}, 68'(err_seen - e0), 68'd0);
        rx_take(w, tag);
    endtask

    task automatic t_raw_bad(input logic [1:0] pre, input int nbits, input int kill, input string tag);
        int e0;
        use_tx = 1'b0;
        e0 = err_seen;
        send_raw(pre, 32'h1234_5678, nbits, kill, 0);
        chk(err_seen > e0, {tag, " error pulse"}, 68'(err_seen - e0), 68'd1);
        chk(!rx_req, {tag, " no delivery"}, 68'(rx_req), 68'd0);
        t_raw_good(32'hC001_D00D, 0, {tag, " recovery"});
    endtask

    task automatic t_overrun();
        int e0;
        use_tx = 1'b1;
        tx_burst(32'hAAAA_5555);
        repeat (40) @(negedge clk);
        e0 = err_seen;
        tx_burst(32'h0F0F_F0F0);
        repeat (20) @(negedge clk);
        chk(err_seen == e0 + 1, "R10 drop pulse", 68'(err_seen - e0), 68'd1);
        chk(rx_req && rx_word == 32'hAAAA_5555, "R10 kept word", 68'(rx_word), 68'h0AAAA_5555);
        rx_take(32'hAAAA_5555, "R10 take");
        repeat (200) @(negedge clk);
        chk(!rx_req, "R10 nothing more", 68'(rx_req), 68'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        tx_req   = 1'b0;
        tx_word  = '0;
        rx_ack   = 1'b0;
        use_tx   = 1'b1;
        man_line = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_loop(32'hA5C3_0F96, "R6 first frame");
        t_loop(32'h0000_0000, "R4 zeros");
        t_loop(32'hFFFF_FFFF, "R4 ones");
        t_gap();
        repeat (3000) @(negedge clk);
        t_loop(32'h8000_0001, "R6 after silence");
        t_raw_good(32'h3C5A_96E1, 3, "R5 mixed jitter");
        t_raw_good(32'hDEAD_BEEF, 1, "R5 slow");
        t_raw_good(32'h0123_4567, 2, "R5 fast");
        t_raw_bad(2'b10, 34, 12, "R7");
        t_raw_bad(2'b10, 22, -1, "R8");
        t_raw_bad(2'b11, 34, -1, "R9");
        t_overrun();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule